// File: doc/BRIEF.md
# Partial-Word Transmit/Receive Lane Adapter for a Serial Flash Controller

This block sits between a 32-bit register bus and the transmit and receive word FIFOs of a serial flash controller. It does not shift serial data and it does not store words. On the transmit side, a write to one of four data addresses pushes the written word into the transmit FIFO. Each pushed word carries a two-bit tag that gives how many of its bytes are valid. The downstream shifter sends only those bytes, starting with byte lane 0. A full word goes to one address. One, two or three valid bytes each have an address of their own.

On the receive side, the receive FIFO delivers raw words. The bytes in each raw word are packed from lane 0 in the order they arrived, and each word has the same kind of count tag. A bus read at the receive address pops one word. The adapter moves the valid bytes into the most significant lanes and clears the lanes below them. Software must let the transmit FIFO drain before it changes to a different data address. The adapter still accepts a write that breaks this rule, but it raises a sticky error flag.

A state machine tracks the width class of the words that have not yet drained. Its states are ST_IDLE, ST_WORD, ST_ONE, ST_TWO and ST_THREE. A data write in any state moves it to the state for that write's class. In a non-idle state, if there is no data write and the FIFO reports empty with no push pending, it returns to ST_IDLE. Otherwise it stays where it is.

Top module: `flash_lane_adapter`

## Requirements
- R1: During and right after reset, txf_push, bus_rvalid and mix_err are 0, and bus_rdata is 0.
- R2: A write to address 0x1C drives txf_push high in the next cycle, with txf_data equal to the written word and txf_tag equal to 0 (tag 0 means four valid bytes).
- R3: Writes to 0x80, 0x84 and 0x88 drive txf_push high in the next cycle, with txf_tag equal to 1, 2 and 3 (that many valid bytes) and txf_data equal to the written word. Lane 0 holds the first byte to send.
- R4: A write to any other address, and any bus read, produces no push.
- R5: A read at address 0x20 while rxf_empty is low drives rxf_pop high in that same cycle. In the next cycle bus_rvalid is 1 and bus_rdata holds the aligned word.
- R6: For a receive tag t, with n = 4 when t = 0 and n = t otherwise, raw byte lane i (i < n) appears in result lane 4-n+i.
- R7: Result lanes 0 through 3-n read as zero.
- R8: A read at 0x20 while rxf_empty is high does not pop. bus_rvalid is still 1 in the next cycle, with bus_rdata equal to 0.
- R9: A read at any other address does not pop and returns 0.
- R10: A data write whose width class differs from a word that has not drained sets mix_err in the next cycle. A word counts as not drained if its push is still pending or txf_empty is low. The offending word is still pushed.
- R11: Repeating the same data address never sets mix_err. Changing address after the FIFO reports empty with no push pending never sets mix_err.
- R12: Once set, mix_err stays at 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr_en | input | 1 | Bus write strobe |
| bus_rd_en | input | 1 | Bus read strobe |
| bus_addr | input | 8 | Bus byte address |
| bus_wdata | input | 32 | Bus write data |
| bus_rvalid | output | 1 | Read data valid, one cycle after a read |
| bus_rdata | output | 32 | Read data |
| txf_push | output | 1 | Push strobe to the transmit FIFO |
| txf_data | output | 32 | Word to push |
| txf_tag | output | 2 | Valid byte count of the pushed word (0 means 4) |
| txf_empty | input | 1 | Transmit FIFO empty flag |
| rxf_pop | output | 1 | Pop strobe to the receive FIFO |
| rxf_data | input | 32 | Head word of the receive FIFO, raw bytes from lane 0 |
| rxf_tag | input | 2 | Valid byte count of the head word (0 means 4) |
| rxf_empty | input | 1 | Receive FIFO empty flag |
| mix_err | output | 1 | Sticky flag for a data address change before drain |

## Verification
The bench tries every ordered pair of the four data addresses, both back to back and with a drain in between. A design that compared the wrong states, or that trusted txf_empty while a push was still pending, would either miss a back-to-back clash or flag a legal change. Every receive tag is read with several byte patterns. An off-by-one in the lane shift would put bytes in the wrong lanes, and a missing mask would leave stale bytes in the lower lanes. Empty reads and reads at other addresses are checked so that a design that popped anyway would be caught, because the next word would be lost. Writes are checked for the zero tag on full words and for mix_err staying set after a legal drain.

// File: rtl/lane_adapt_pkg.sv
package lane_adapt_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_WORD  = 3'd1,
        ST_ONE   = 3'd2,
        ST_TWO   = 3'd3,
        ST_THREE = 3'd4
    } lane_mode_e;

    // Width class of a pushed word, from its byte-count tag (0 = full word).
    function automatic lane_mode_e mode_of_tag(input logic [1:0] tag);
        lane_mode_e m;
        unique case (tag)
            2'd0: m = ST_WORD;
            2'd1: m = ST_ONE;
            2'd2: m = ST_TWO;
            2'd3: m = ST_THREE;
            default: m = ST_IDLE;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/tx_tagger.sv
module tx_tagger #(
    parameter int              ADDR_W  = 8,
    parameter int              DATA_W  = 32,
    parameter logic [ADDR_W-1:0] A_WORD  = 'h1C,
    parameter logic [ADDR_W-1:0] A_ONE   = 'h80,
    parameter logic [ADDR_W-1:0] A_TWO   = 'h84,
    parameter logic [ADDR_W-1:0] A_THREE = 'h88,
    localparam int             LANES   = DATA_W / 8,
    localparam int             TAG_W   = $clog2(LANES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic              hit,
    output logic [TAG_W-1:0]  hit_tag,
    output logic              txf_push,
    output logic [DATA_W-1:0] txf_data,
    output logic [TAG_W-1:0]  txf_tag
);

    // Address decode: which data port, and how many bytes it carries.
    always_comb begin
        hit     = 1'b0;
        hit_tag = '0;
        if (wr_en) begin
            if (addr == A_WORD) begin
                hit     = 1'b1;
                hit_tag = '0;
            end else if (addr == A_ONE) begin
                hit     = 1'b1;
                hit_tag = TAG_W'(1);
            end else if (addr == A_TWO) begin
                hit     = 1'b1;
                hit_tag = TAG_W'(2);
            end else if (addr == A_THREE) begin
                hit     = 1'b1;
                hit_tag = TAG_W'(3);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            txf_push <= 1'b0;
            txf_data <= '0;
            txf_tag  <= '0;
        end else begin
            txf_push <= hit;
            if (hit) begin
                txf_data <= wdata;
                txf_tag  <= hit_tag;
            end
        end
    end

    assert_full_tag_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == A_WORD) |=> (txf_push && txf_tag == '0));

    assert_three_tag_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == A_THREE) |=> (txf_push && txf_tag == TAG_W'(3)));

    assert_push_needs_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> !txf_push);

endmodule

// File: rtl/mix_monitor.sv
module mix_monitor
    import lane_adapt_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       hit,
    input  logic [1:0] hit_tag,
    input  logic       txf_empty,
    input  logic       txf_push,
    output logic       mix_err
);

    lane_mode_e state_q, state_d;
    lane_mode_e tag_mode;
    logic       drained;
    logic       clash;

    assign tag_mode = mode_of_tag(hit_tag);
    assign drained  = txf_empty && !txf_push;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (hit) state_d = tag_mode;
            end
            ST_WORD, ST_ONE, ST_TWO, ST_THREE: begin
                if (hit)          state_d = tag_mode;
                else if (drained) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        clash = hit && (state_q != ST_IDLE) && (tag_mode != state_q) && !drained;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)     mix_err <= 1'b0;
        else if (clash) mix_err <= 1'b1;
    end

    assert_clash_flags_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && state_q == ST_ONE && hit_tag == 2'd2 && !txf_empty) |=> mix_err);

    assert_idle_legal_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && !mix_err) |=> !mix_err);

    assert_sticky_R12: assert property (@(posedge clk) disable iff (!rst_n)
        mix_err |=> mix_err);

endmodule

// File: rtl/rx_aligner.sv
module rx_aligner #(
    parameter int              ADDR_W = 8,
    parameter int              DATA_W = 32,
    parameter logic [ADDR_W-1:0] A_RX   = 'h20,
    localparam int             LANES  = DATA_W / 8,
    localparam int             TAG_W  = $clog2(LANES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] rxf_data,
    input  logic [TAG_W-1:0]  rxf_tag,
    input  logic              rxf_empty,
    output logic              rxf_pop,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data
);

    logic [DATA_W-1:0] aligned;

    assign rxf_pop = rd_en && (addr == A_RX) && !rxf_empty;

    // One byte mux per result lane: shift valid bytes up to the top lanes.
    for (genvar j = 0; j < LANES; j++) begin : g_lane
        logic [7:0] lane_byte;
        always_comb begin
            int n;
            int src;
            n   = (rxf_tag == '0) ? LANES : int'(rxf_tag);
            src = j - (LANES - n);
            lane_byte = 8'h00;
            if (src >= 0) lane_byte = rxf_data[8*src +: 8];
        end
        assign aligned[8*j +: 8] = lane_byte;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= rd_en;
            rd_data  <= rxf_pop ? aligned : '0;
        end
    end

    assert_pop_answers_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rxf_pop |=> rd_valid);

    assert_one_byte_low_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rxf_pop && rxf_tag == TAG_W'(1)) |=> (rd_data[DATA_W-9:0] == '0));

    assert_empty_read_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == A_RX && rxf_empty) |=> (rd_valid && rd_data == '0));

    assert_other_read_no_pop_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr != A_RX) |-> !rxf_pop);

endmodule

// File: rtl/flash_lane_adapter.sv
module flash_lane_adapter #(
    parameter int              ADDR_W  = 8,
    parameter int              DATA_W  = 32,
    parameter logic [ADDR_W-1:0] A_WORD  = 'h1C,
    parameter logic [ADDR_W-1:0] A_ONE   = 'h80,
    parameter logic [ADDR_W-1:0] A_TWO   = 'h84,
    parameter logic [ADDR_W-1:0] A_THREE = 'h88,
    parameter logic [ADDR_W-1:0] A_RX    = 'h20,
    localparam int             LANES   = DATA_W / 8,
    localparam int             TAG_W   = $clog2(LANES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr_en,
    input  logic              bus_rd_en,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic              bus_rvalid,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              txf_push,
    output logic [DATA_W-1:0] txf_data,
    output logic [TAG_W-1:0]  txf_tag,
    input  logic              txf_empty,
    output logic              rxf_pop,
    input  logic [DATA_W-1:0] rxf_data,
    input  logic [TAG_W-1:0]  rxf_tag,
    input  logic              rxf_empty,
    output logic              mix_err
);

    logic             hit;
    logic [TAG_W-1:0] hit_tag;

    tx_tagger #(
        .ADDR_W (ADDR_W), .DATA_W (DATA_W),
        .A_WORD (A_WORD), .A_ONE (A_ONE), .A_TWO (A_TWO), .A_THREE (A_THREE)
    ) u_tagger (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (bus_wr_en),
        .addr     (bus_addr),
        .wdata    (bus_wdata),
        .hit      (hit),
        .hit_tag  (hit_tag),
        .txf_push (txf_push),
        .txf_data (txf_data),
        .txf_tag  (txf_tag)
    );

    mix_monitor u_monitor (
        .clk       (clk),
        .rst_n     (rst_n),
        .hit       (hit),
        .hit_tag   (hit_tag),
        .txf_empty (txf_empty),
        .txf_push  (txf_push),
        .mix_err   (mix_err)
    );

    rx_aligner #(
        .ADDR_W (ADDR_W), .DATA_W (DATA_W), .A_RX (A_RX)
    ) u_aligner (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_en     (bus_rd_en),
        .addr      (bus_addr),
        .rxf_data  (rxf_data),
        .rxf_tag   (rxf_tag),
        .rxf_empty (rxf_empty),
        .rxf_pop   (rxf_pop),
        .rd_valid  (bus_rvalid),
        .rd_data   (bus_rdata)
    );

    assert_reads_never_push_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd_en && !bus_wr_en) |=> !txf_push);

endmodule

// File: tb/test_flash_lane_adapter.sv
module test_flash_lane_adapter;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr_en = 1'b0;
    logic        bus_rd_en = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_rvalid;
    logic [31:0] bus_rdata;
    logic        txf_push;
    logic [31:0] txf_data;
    logic [1:0]  txf_tag;
    logic        txf_empty;
    logic        rxf_pop;
    logic [31:0] rxf_data;
    logic [1:0]  rxf_tag;
    logic        rxf_empty;
    logic        mix_err;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // Transmit FIFO occupancy model
    int tx_cnt;
    logic tx_drain = 1'b0;
    assign txf_empty = (tx_cnt == 0);
    always @(posedge clk) begin
        if (!rst_n) tx_cnt <= 0;
        else        tx_cnt <= tx_cnt + int'(txf_push) - int'(tx_drain);
    end

    // Receive FIFO model
    logic [31:0] rxq_d [16];
    logic [1:0]  rxq_t [16];
    int rx_wr = 0;
    int rx_rd = 0;
    assign rxf_empty = (rx_rd == rx_wr);
    assign rxf_data  = rxq_d[rx_rd % 16];
    assign rxf_tag   = rxq_t[rx_rd % 16];
    always @(posedge clk) if (rxf_pop) rx_rd <= rx_rd + 1;

    always #10 clk = ~clk;

    flash_lane_adapter i_flash_lane_adapter (
        .clk(clk), .rst_n(rst_n), .bus_wr_en(bus_wr_en), .bus_rd_en(bus_rd_en),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rvalid(bus_rvalid),
        .bus_rdata(bus_rdata), .txf_push(txf_push), .txf_data(txf_data),
        .txf_tag(txf_tag), .txf_empty(txf_empty), .rxf_pop(rxf_pop),
        .rxf_data(rxf_data), .rxf_tag(rxf_tag), .rxf_empty(rxf_empty),
        .mix_err(mix_err)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr_en = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr_en = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic popped);
        @(negedge clk);
        bus_rd_en = 1'b1; bus_addr = a;
        #1 popped = rxf_pop;
        @(negedge clk);
        bus_rd_en = 1'b0;
    endtask

    task automatic drain();
        @(negedge clk);
        while (tx_cnt > 0) begin
            tx_drain = 1'b1;
            @(negedge clk);
        end
        tx_drain = 1'b0;
        @(negedge clk);
    endtask

    function automatic logic [7:0] addr_of(input int k);
        case (k)
            0: return 8'h1C;
            1: return 8'h80;
            2: return 8'h84;
            default: return 8'h88;
        endcase
    endfunction

    initial begin
        logic [31:0] pats [3];
        logic popped;
        pats[0] = 32'h0302_0100; pats[1] = 32'hA5C3_1E7F; pats[2] = 32'hFFFF_0000;

        // R1 reset state
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check(txf_push == 0 && bus_rvalid == 0 && mix_err == 0, "R1 reset flags",
              {29'd0, txf_push, bus_rvalid, mix_err}, 32'd0);
        check(bus_rdata == 0, "R1 reset rdata", bus_rdata, 32'd0);
        rst_n = 1'b1;

        // R2/R3 transmit tagging sweep
        for (int k = 0; k < 4; k++) begin
            for (int p = 0; p < 3; p++) begin
                bus_write(addr_of(k), pats[p]);
                check(txf_push == 1'b1, k == 0 ? "R2 push" : "R3 push",
                      {31'd0, txf_push}, 32'd1);
                check(txf_data == pats[p], k == 0 ? "R2 data" : "R3 data",
                      txf_data, pats[p]);
                check(txf_tag == 2'(k), k == 0 ? "R2 tag" : "R3 tag",
                      {30'd0, txf_tag}, 32'(k));
            end
            drain();
        end
        check(mix_err == 1'b0, "R11 drained address changes", {31'd0, mix_err}, 32'd0);

        // R4 other writes and reads never push
        bus_write(8'h20, 32'h1234_5678);
        check(txf_push == 1'b0, "R4 write 0x20", {31'd0, txf_push}, 32'd0);
        bus_write(8'h8C, 32'h1234_5678);
        check(txf_push == 1'b0, "R4 write 0x8C", {31'd0, txf_push}, 32'd0);
        bus_read(8'h1C, popped);
        check(txf_push == 1'b0, "R4 read 0x1C", {31'd0, txf_push}, 32'd0);

        // R5/R6/R7 receive alignment sweep
        for (int t = 0; t < 4; t++) begin
            for (int p = 0; p < 3; p++) begin
                logic [31:0] raw, exp, lowmask;
                int n;
                raw = {pats[p][7:0], pats[(p+1)%3][15:8] ^ 8'h5A, pats[p][23:16] ^ 8'h3C,
                       8'h11 + 8'(t*16 + p)};
                n = (t == 0) ? 4 : t;
                exp = raw << (8 * (4 - n));
                lowmask = (n == 4) ? 32'd0 : ((32'd1 << (8 * (4 - n))) - 32'd1);
                @(negedge clk);
                rxq_d[rx_wr % 16] = raw; rxq_t[rx_wr % 16] = 2'(t); rx_wr = rx_wr + 1;
                bus_read(8'h20, popped);
                check(popped == 1'b1, "R5 pop on read", {31'd0, popped}, 32'd1);
                check(bus_rvalid == 1'b1, "R5 rvalid", {31'd0, bus_rvalid}, 32'd1);
                check(bus_rdata == exp, "R6 aligned data", bus_rdata, exp);
                check((bus_rdata & lowmask) == 0, "R7 unused lanes zero",
                      bus_rdata & lowmask, 32'd0);
            end
        end

        // R8 read while empty
        bus_read(8'h20, popped);
        check(popped == 1'b0, "R8 no pop when empty", {31'd0, popped}, 32'd0);
        check(bus_rvalid == 1'b1 && bus_rdata == 0, "R8 empty read zero", bus_rdata, 32'd0);

        // R9 read elsewhere with data waiting
        @(negedge clk);
        rxq_d[rx_wr % 16] = 32'hDEAD_BEEF; rxq_t[rx_wr % 16] = 2'd0; rx_wr = rx_wr + 1;
        bus_read(8'h24, popped);
        check(popped == 1'b0, "R9 no pop other addr", {31'd0, popped}, 32'd0);
        check(bus_rdata == 0, "R9 other addr zero", bus_rdata, 32'd0);
        bus_read(8'h20, popped);
        check(bus_rdata == 32'hDEAD_BEEF, "R9 word kept", bus_rdata, 32'hDEAD_BEEF);

        // R10/R11 every ordered address pair, back to back and drained
        for (int a = 0; a < 4; a++) begin
            for (int b = 0; b < 4; b++) begin
                do_reset();
                bus_write(addr_of(a), 32'h0A0B_0C0D);
                bus_write(addr_of(b), 32'h1A1B_1C1D);
                check(mix_err == (a != b), a != b ? "R10 clash flagged" : "R11 same addr",
                      {31'd0, mix_err}, 32'(a != b));
                @(negedge clk);
                check(tx_cnt == 2, "R10 both words pushed", 32'(tx_cnt), 32'd2);
                if (a != b) begin
                    drain();
                    bus_write(addr_of(a), 32'h0);
                    drain();
                    check(mix_err == 1'b1, "R12 sticky", {31'd0, mix_err}, 32'd1);
                end
                do_reset();
                bus_write(addr_of(a), 32'h0A0B_0C0D);
                drain();
                bus_write(addr_of(b), 32'h1A1B_1C1D);
                @(negedge clk);
                check(mix_err == 1'b0, "R11 change after drain", {31'd0, mix_err}, 32'd0);
            end
        end

        // R12 reset clears the flag
        bus_write(8'h80, 32'h1);
        bus_write(8'h1C, 32'h2);
        do_reset();
        check(mix_err == 1'b0, "R12 cleared by reset", {31'd0, mix_err}, 32'd0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual running expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule